// File: doc/BRIEF.md
# Multi-Mode 16-bit Event Timer

This block is a 16-bit up/down counter paired with a 16-bit reload/capture register. It advances either on a prescaled system-clock tick (timer function) or on falling edges of an external count pin that is sampled on that same tick (counter function). A set of control inputs picks one of six operating modes: stopped, baud-rate (decoded only, the counter holds), plain auto-reload, auto-reload with an external direction pin, capture of the running count on a falling edge of a capture pin, and a frequency generator that toggles an output on every overflow.

The sampling tick is set by a speed-class input and a double-speed input together with a 4-bit prescale value. A falling edge needs one high sample and then one low sample. This caps the external count rate at half the tick rate, and a pulse that falls between two ticks is not seen. Parallel load strobes write the count and the reload register. A clear input resets the sticky overflow and capture-event flags.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count, the reload/capture register, both flags and the clock output are all 0.
- R2: Mode priority is: run low gives stopped; otherwise baud select gives baud mode; then capture select gives capture; then output enable gives frequency generator; then up/down enable gives up/down auto-reload; else plain auto-reload.
- R3: The tick occurs every clock when fast_mode=1 and dbl_speed=0. It occurs every prescale+1 clocks when fast_mode=1 and dbl_speed=1, or when fast_mode=0 and dbl_speed=0. It occurs every 2*(prescale+1) clocks when fast_mode=0 and dbl_speed=1. The first tick comes that many clocks after run rises.
- R4: With cnt_sel=1, the count advances once for each tick whose sample of cnt_pin is low while the previous tick's sample was high. The new value is visible one clock after the edge that sees the low sample.
- R5: A low pulse on cnt_pin that no tick samples adds nothing to the count.
- R6: In auto-reload mode, a step from 0xFFFF loads the reload register value (MIN) into the count and sets ovf_flag; any other step adds 1.
- R7: In up/down mode with dir_pin=0, a step at a count equal to MIN loads 0xFFFF and sets ovf_flag; any other step subtracts 1. With dir_pin=1 it behaves as R6.
- R8: In capture mode, a falling edge on cap_pin (sampled on ticks like R4) copies the count as it stood before that clock's step into the capture register and sets ext_flag. In other modes cap_pin has no effect.
- R9: In capture mode a step from 0xFFFF wraps to 0x0000 and sets ovf_flag, with no reload.
- R10: In frequency-generator mode the count reloads as in R6, and clk_out inverts on every overflow.
- R11: In the stopped and baud modes the count does not change.
- R12: load_cnt writes load_data into the count and overrides that clock's step; load_rld writes the reload register. Flags are sticky and are cleared by flag_clr; a set in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables counting; low stops the timer |
| cap_sel | input | 1 | Selects capture mode |
| updown_en | input | 1 | Enables the direction pin in auto-reload |
| out_en | input | 1 | Selects frequency-generator mode |
| baud_sel | input | 1 | Selects baud-rate mode (counter holds) |
| cnt_sel | input | 1 | 1 counts cnt_pin falling edges, 0 counts ticks |
| fast_mode | input | 1 | 1 selects the fast speed class |
| dbl_speed | input | 1 | Double-speed bit, see R3 |
| prescale | input | 4 | Prescale value |
| cnt_pin | input | 1 | External count input |
| cap_pin | input | 1 | External capture input |
| dir_pin | input | 1 | Direction in up/down mode, 1 = up |
| load_cnt | input | 1 | Write strobe for the count |
| load_rld | input | 1 | Write strobe for the reload register |
| load_data | input | 16 | Data for either write strobe |
| flag_clr | input | 1 | Clears both flags |
| count | output | 16 | Current count |
| capture | output | 16 | Reload/capture register |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky capture-event flag |
| clk_out | output | 1 | Frequency-generator output |

## Verification
The assertions assume that the external pins change no faster than the design samples them, and that loads happen only in clocks where the step they check is suppressed. They also assume the direction pin is steady for the clock in which a step is taken. The bench drives every pin and strobe on the falling clock edge, so each level is in place before the sampling edge. It holds each counting pulse for at least one tick period, except for the one pulse meant to fall between ticks. It applies loads only while run is low, or in a clock where the override itself is the thing being checked. The prescaler sweep covers all sixteen prescale values in three speed classes, and expected counts are computed by integer division.

// File: rtl/evt_timer_pkg.sv
// Shared types for the event timer: operating-mode encoding and its decode.
package evt_timer_pkg;

    typedef enum logic [2:0] {
        MODE_OFF,
        MODE_BAUD,
        MODE_CAPTURE,
        MODE_FREQGEN,
        MODE_UPDOWN,
        MODE_RELOAD
    } tmr_mode_e;

    // Priority decode of the control bits into one mode (R2).
    function automatic tmr_mode_e decode_mode(
        input logic run,
        input logic baud,
        input logic cap,
        input logic oe,
        input logic ud
    );
        if (!run)      return MODE_OFF;
        else if (baud) return MODE_BAUD;
        else if (cap)  return MODE_CAPTURE;
        else if (oe)   return MODE_FREQGEN;
        else if (ud)   return MODE_UPDOWN;
        else           return MODE_RELOAD;
    endfunction

endpackage

// File: rtl/evt_timer_prescaler.sv
// Tick generator: divides the system clock by a period chosen from the
// speed class, the double-speed bit and the prescale value.
// Assumes: the divider restarts whenever run is low.
module evt_timer_prescaler #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            fast_mode,
    input  logic            dbl_speed,
    input  logic [PS_W-1:0] prescale,
    output logic            tick
);
    localparam int DIV_W = PS_W + 2;

    logic [DIV_W-1:0] base;
    logic [DIV_W-1:0] period;
    logic [DIV_W-1:0] div_q;

    // Select the division period from the speed controls.
    always_comb begin
        base = {2'b00, prescale} + DIV_W'(1);
        if (fast_mode) period = dbl_speed ? base : DIV_W'(1);
        else           period = dbl_speed ? (base << 1) : base;
    end

    assign tick = run && (div_q >= period - DIV_W'(1));

    // Free-running divider, cleared while stopped and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           div_q <= '0;
        else if (!run || tick) div_q <= '0;
        else                   div_q <= div_q + DIV_W'(1);
    end

    AST_FAST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fast_mode && !dbl_speed) |-> tick); // R3
    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick); // R11

endmodule

// File: rtl/evt_timer_edge_sampler.sv
// Samples a pin on each tick and flags a high-then-low pair of samples.
// Assumes: the pin is held for at least one tick period per level.
module evt_timer_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic smp_q;

    // Keep the sample taken at the previous tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    smp_q <= 1'b0;
        else if (tick) smp_q <= pin;
    end

    assign fall = tick && smp_q && !pin;

    AST_FALL_LEAVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !smp_q); // R4

endmodule

// File: rtl/evt_timer_count_core.sv
// Count register, reload/capture register, flags and toggle output.
// Performs one step per enabled clock according to the decoded mode.
// Assumes: load strobes are one clock wide and win over the step.
module evt_timer_count_core
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode,
    input  logic             step_en,
    input  logic             cap_fall,
    input  logic             dir_up,
    input  logic             load_cnt,
    input  logic             load_rld,
    input  logic [CNT_W-1:0] load_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] rld_q,
    output logic             ovf_flag,
    output logic             ext_flag,
    output logic             clk_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] nxt;
    logic             wrap;
    logic             ovf_evt;
    logic             cap_evt;
    logic             reload_up;

    assign reload_up = (mode == MODE_RELOAD) || (mode == MODE_FREQGEN) ||
                       ((mode == MODE_UPDOWN) && dir_up);

    // Next count and wrap event for the current mode.
    always_comb begin
        nxt  = count;
        wrap = 1'b0;
        if (step_en) begin
            if (reload_up) begin
                if (count == CNT_MAX) begin
                    nxt  = rld_q;
                    wrap = 1'b1;
                end else begin
                    nxt = count + CNT_W'(1);
                end
            end else if (mode == MODE_UPDOWN) begin
                if (count == rld_q) begin
                    nxt  = CNT_MAX;
                    wrap = 1'b1;
                end else begin
                    nxt = count - CNT_W'(1);
                end
            end else if (mode == MODE_CAPTURE) begin
                nxt  = count + CNT_W'(1);
                wrap = (count == CNT_MAX);
            end
        end
    end

    assign ovf_evt = wrap && !load_cnt;
    assign cap_evt = (mode == MODE_CAPTURE) && cap_fall;

    // Count register with load override.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (load_cnt) count <= load_data;
        else               count <= nxt;
    end

    // Reload/capture register: a capture wins over a software load.
    always_ff @(posedge clk) begin
        if (!rst_n)        rld_q <= '0;
        else if (cap_evt)  rld_q <= count;
        else if (load_rld) rld_q <= load_data;
    end

    // Sticky flags, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            ext_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_evt || (ovf_flag && !flag_clr);
            ext_flag <= cap_evt || (ext_flag && !flag_clr);
        end
    end

    // Toggle output on each overflow in frequency-generator mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                clk_out <= 1'b0;
        else if (mode == MODE_FREQGEN && ovf_evt) clk_out <= !clk_out;
    end

    AST_RELOAD_TO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD && step_en && count == CNT_MAX && !load_cnt)
        |=> (count == $past(rld_q) && ovf_flag)); // R6
    AST_DOWN_TO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UPDOWN && !dir_up && step_en && count == rld_q && !load_cnt)
        |=> (count == CNT_MAX && ovf_flag)); // R7
    AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CAPTURE && cap_fall) |=> (rld_q == $past(count) && ext_flag)); // R8
    AST_CAPTURE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CAPTURE && step_en && count == CNT_MAX && !load_cnt)
        |=> (count == '0 && ovf_flag)); // R9
    AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREQGEN && step_en && count == CNT_MAX && !load_cnt)
        |=> (clk_out != $past(clk_out))); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_OFF || mode == MODE_BAUD) && !load_cnt)
        |=> (count == $past(count))); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag); // R12

endmodule

// File: rtl/evt_timer16.sv
// Top of the multi-mode 16-bit event timer: mode decode, tick generation,
// pin sampling and the counting core.
// Assumes: pins are synchronous to clk (synchronisers sit outside).
module evt_timer16
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cap_sel,
    input  logic             updown_en,
    input  logic             out_en,
    input  logic             baud_sel,
    input  logic             cnt_sel,
    input  logic             fast_mode,
    input  logic             dbl_speed,
    input  logic [PS_W-1:0]  prescale,
    input  logic             cnt_pin,
    input  logic             cap_pin,
    input  logic             dir_pin,
    input  logic             load_cnt,
    input  logic             load_rld,
    input  logic [CNT_W-1:0] load_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture,
    output logic             ovf_flag,
    output logic             ext_flag,
    output logic             clk_out
);
    tmr_mode_e mode;
    logic      tick;
    logic      cnt_fall;
    logic      cap_fall;
    logic      step_en;

    assign mode    = decode_mode(run, baud_sel, cap_sel, out_en, updown_en);
    assign step_en = cnt_sel ? cnt_fall : tick;

    evt_timer_prescaler #(.PS_W(PS_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .fast_mode (fast_mode),
        .dbl_speed (dbl_speed),
        .prescale  (prescale),
        .tick      (tick)
    );

    evt_timer_edge_sampler u_cnt_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .pin   (cnt_pin),
        .fall  (cnt_fall)
    );

    evt_timer_edge_sampler u_cap_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .pin   (cap_pin),
        .fall  (cap_fall)
    );

    evt_timer_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .step_en   (step_en),
        .cap_fall  (cap_fall),
        .dir_up    (dir_pin),
        .load_cnt  (load_cnt),
        .load_rld  (load_rld),
        .load_data (load_data),
        .flag_clr  (flag_clr),
        .count     (count),
        .rld_q     (capture),
        .ovf_flag  (ovf_flag),
        .ext_flag  (ext_flag),
        .clk_out   (clk_out)
    );

endmodule

// File: tb/evt_timer16_tb.sv
`timescale 1ns/1ps
module evt_timer16_tb;
    logic        clk = 1'b0;
    logic        rst_n, run, cap_sel, updown_en, out_en, baud_sel, cnt_sel;
    logic        fast_mode, dbl_speed, cnt_pin, cap_pin, dir_pin;
    logic        load_cnt, load_rld, flag_clr;
    logic [3:0]  prescale;
    logic [15:0] load_data, count, capture;
    logic        ovf_flag, ext_flag, clk_out;
    int          n_chk = 0;
    int          n_err = 0;

    always #2 clk = ~clk;

    evt_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cap_sel(cap_sel),
        .updown_en(updown_en), .out_en(out_en), .baud_sel(baud_sel),
        .cnt_sel(cnt_sel), .fast_mode(fast_mode), .dbl_speed(dbl_speed),
        .prescale(prescale), .cnt_pin(cnt_pin), .cap_pin(cap_pin),
        .dir_pin(dir_pin), .load_cnt(load_cnt), .load_rld(load_rld),
        .load_data(load_data), .flag_clr(flag_clr), .count(count),
        .capture(capture), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
        .clk_out(clk_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_all();
        run = 0; cap_sel = 0; updown_en = 0; out_en = 0; baud_sel = 0;
        cnt_sel = 0; fast_mode = 1; dbl_speed = 0; prescale = 0; dir_pin = 0;
    endtask

    task automatic ld(input logic [15:0] c, input logic [15:0] r);
        load_data = c; load_cnt = 1;
        @(negedge clk);
        load_cnt = 0; load_data = r; load_rld = 1;
        @(negedge clk);
        load_rld = 0;
    endtask

    task automatic clear_flags();
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; stop_all(); cnt_pin = 1; cap_pin = 1;
        load_cnt = 0; load_rld = 0; load_data = 0; flag_clr = 0;
        wait_n(3);
        rst_n = 1;
        wait_n(1);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 capture", capture, 0);
        chk("R1 flags", {ovf_flag, ext_flag, clk_out}, 0);

        // R6 auto-reload sweep, R12 set beats clear
        ld(16'hFFF0, 16'hFFF0);
        run = 1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            flag_clr = 0;
            chk("R6 count", count, 16'hFFF0 + (k % 16));
            if (k == 15) chk("R6 ovf before", ovf_flag, 0);
            if (k == 15) flag_clr = 1;
            if (k == 16) chk("R12 set wins over clear", ovf_flag, 1);
        end
        run = 0;
        clear_flags();
        chk("R12 clear", ovf_flag, 0);

        // R12 load overrides step while running
        run = 1; load_data = 16'h0100; load_cnt = 1;
        @(negedge clk);
        load_cnt = 0;
        chk("R12 load during run", count, 16'h0100);
        run = 0;

        // R3 prescaler sweep over three speed classes
        for (int m = 0; m < 3; m++) begin
            for (int ps = 0; ps < 16; ps++) begin
                int per;
                stop_all();
                ld(16'h0000, 16'h0000);
                fast_mode = (m == 0);
                dbl_speed = (m != 1);
                prescale = 4'(ps);
                per = (m == 2) ? 2 * (ps + 1) : ps + 1;
                run = 1;
                wait_n(40);
                chk($sformatf("R3 m%0d ps%0d", m, ps), count, 40 / per);
                run = 0;
            end
        end
        // R3 prescale ignored in fast class without double speed
        stop_all(); ld(0, 0); prescale = 7; run = 1;
        wait_n(40);
        chk("R3 fast no prescale", count, 40);
        run = 0;

        // R4 counter function, fast class, mixed pulse widths
        stop_all(); ld(0, 0); cnt_sel = 1; run = 1;
        wait_n(1);
        for (int i = 1; i <= 20; i++) begin
            cnt_pin = 0;
            chk("R4 before edge", count, i - 1);
            wait_n(1);
            chk("R4 one clock after", count, i);
            wait_n(i % 3);
            cnt_pin = 1;
            wait_n((i % 2) + 1);
        end
        run = 0;

        // R5 compat class period 6: short pulse missed, long pulse counted
        stop_all(); ld(0, 0); cnt_sel = 1; fast_mode = 0; prescale = 5; run = 1;
        wait_n(7);  cnt_pin = 0;
        wait_n(2);  cnt_pin = 1;
        wait_n(15);
        chk("R5 short pulse missed", count, 0);
        wait_n(1);  cnt_pin = 0;
        wait_n(4);
        chk("R4 compat before tick", count, 0);
        wait_n(1);
        chk("R4 compat at tick", count, 1);
        cnt_pin = 1; run = 0;

        // R7 up/down
        stop_all(); ld(16'h0008, 16'h0005); clear_flags();
        updown_en = 1; dir_pin = 0; run = 1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R7 down", count, (k <= 3) ? 32'(8 - k) : 32'(16'hFFFF - (k - 4)));
            chk("R7 down ovf", ovf_flag, k >= 4);
        end
        dir_pin = 1; flag_clr = 1;
        for (int j = 1; j <= 8; j++) begin
            @(negedge clk);
            flag_clr = 0;
            chk("R7 up", count, (j <= 6) ? 32'(16'hFFF9 + j) : 32'(5 + (j - 7)));
            chk("R7 up ovf", ovf_flag, j >= 7);
        end
        run = 0; clear_flags();

        // R8 capture and R9 wrap without reload
        stop_all(); ld(16'hFFF8, 16'h1111); cap_sel = 1; run = 1;
        wait_n(3);  cap_pin = 0;
        wait_n(1);
        chk("R8 captured value", capture, 16'hFFFB);
        chk("R8 ext flag", ext_flag, 1);
        cap_pin = 1;
        wait_n(3);
        chk("R9 at max", {ovf_flag, count}, {1'b0, 16'hFFFF});
        wait_n(1);
        chk("R9 wrap to zero", {ovf_flag, count}, {1'b1, 16'h0000});
        wait_n(1);
        chk("R9 no reload", count, 1);
        run = 0; clear_flags();

        // R10 frequency generator
        stop_all(); ld(16'hFFFD, 16'hFFFD); out_en = 1; run = 1;
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            chk("R10 clk_out", clk_out, (n / 3) % 2);
            chk("R10 count", count, 16'hFFFD + (n % 3));
        end
        run = 0;

        // R2 capture outranks output enable
        stop_all(); ld(16'h3000, 16'h2000); cap_sel = 1; out_en = 1; run = 1;
        wait_n(2); cap_pin = 0;
        wait_n(1);
        chk("R2 capture over freqgen", capture, 16'h3002);
        cap_pin = 1; run = 0;
        // R2 output enable outranks up/down
        stop_all(); ld(16'hFFFE, 16'h0010);
        begin
            logic co;
            co = clk_out;
            out_en = 1; updown_en = 1; dir_pin = 0; run = 1;
            wait_n(3);
            chk("R2 freqgen over updown", count, 16'h0011);
            chk("R2 toggle", clk_out, !co);
        end
        run = 0;

        // R8 cap_pin ignored outside capture mode
        stop_all(); ld(16'h0040, 16'h0777); clear_flags(); run = 1;
        wait_n(2); cap_pin = 0;
        wait_n(2);
        chk("R8 no capture in reload", capture, 16'h0777);
        chk("R8 no ext flag", ext_flag, 0);
        cap_pin = 1; run = 0;

        // R11 baud and stopped modes hold
        stop_all(); ld(16'h0ABC, 16'h0000); baud_sel = 1; run = 1;
        wait_n(10);
        chk("R11 baud holds", count, 16'h0ABC);
        baud_sel = 0; run = 0;
        wait_n(10);
        chk("R11 off holds", count, 16'h0ABC);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule